// File: doc/BRIEF.md
# Interval Timer with Compare Interrupt

This block is a free-running cycle counter paired with a 32-bit write-only compare register. The two share one register address. A read strobe at that address returns the live counter. A write strobe at the same address loads the compare register and leaves the counter alone. The counter is 32 or 64 bits wide, chosen by a parameter. The compare is always matched against the low 32 bits of the counter only.

When the low half of the counter reaches the compare value, a sticky pending flag is set. The interrupt output is that flag gated by an enable input. Software clears the flag with a one-cycle acknowledge pulse. Because the match is an equality test, a deadline that is already behind the counter is not reported early. It is reached only after the low 32 bits wrap around.

Top module: `itm_timer`

## Requirements
- R1: The counter increases by exactly one on every clock cycle after reset. In the 64-bit variant, the carry out of bit 31 advances bits 63..32.
- R2: The parameter `CNT_W` selects a counter width of 32 or 64 bits, and `reg_rdata` has that width. Any other value stops elaboration.
- R3: A write strobe at address `TIMER_ADDR` loads `reg_wdata` into the compare register on that clock edge. The compare value is never visible on `reg_rdata`.
- R4: With `reg_rd` high and `reg_addr` equal to `TIMER_ADDR`, `reg_rdata` shows the counter in the same cycle; otherwise `reg_rdata` is zero. A write leaves the counter stepping by one. A write at any other address changes nothing.
- R5: While the low 32 bits of the counter equal the compare value, the pending flag is set at the next clock edge, whatever the upper counter bits hold.
- R6: A compare value already behind the low counter bits produces no event until those bits wrap around and reach it. Each pass of the low 32 bits produces at most one event.
- R7: The pending flag stays set until a cycle with `irq_ack` high clears it. If a match and an acknowledge fall in the same cycle, the flag ends up set.
- R8: `irq` is high exactly when the pending flag is set and `irq_mask_en` is high. A match that occurs while the mask is low is still recorded.
- R9: Reset loads the counter with `INIT_COUNT` (zero by default), sets the compare register to all ones and clears the pending flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | ADDR_W | Register address |
| reg_rd | input | 1 | Read strobe |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data (compare value) |
| reg_rdata | output | CNT_W | Read data (counter value, zero when not selected) |
| irq_mask_en | input | 1 | Interrupt enable; 1 lets the pending flag through |
| irq_ack | input | 1 | Clears the pending flag |
| irq | output | 1 | Interrupt request |

## Verification
The bench starts the counter a few thousand cycles short of a low-half wrap. Two behaviours depend on that wrap. A deadline numerically below the counter must fire only after the wrap, and on the exact cycle. The upper half must carry. A design that compared with a magnitude test would fire at once, and one that matched all 64 bits would never fire. An acknowledge placed on the match cycle catches a design that lets the clear win. A masked match followed by enabling the mask catches a design that drops events while masked. A second reset followed by no writes exposes a compare register that does not come up as all ones: the first event must land exactly when the low half reads all ones.

// File: rtl/itm_pkg.sv
package itm_pkg;
   localparam int CMP_W = 32;
   typedef logic [CMP_W-1:0] cmp_t;
endpackage

// File: rtl/itm_counter.sv
module itm_counter #(
   parameter int               CNT_W      = 64,
   parameter logic [CNT_W-1:0] INIT_COUNT = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   output logic [CNT_W-1:0] cnt
);
   localparam int HALF_W = itm_pkg::CMP_W;

   generate
      if (CNT_W == 2*HALF_W) begin : g_split
         logic [HALF_W-1:0] lo_q, hi_q;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               lo_q <= INIT_COUNT[HALF_W-1:0];
               hi_q <= INIT_COUNT[CNT_W-1:HALF_W];
            end else begin
               lo_q <= lo_q + 1'b1;
               if (&lo_q) hi_q <= hi_q + 1'b1;
            end
         end
         assign cnt = {hi_q, lo_q};
      end else begin : g_flat
         logic [CNT_W-1:0] c_q;
         always_ff @(posedge clk) begin
            if (!rst_n) c_q <= INIT_COUNT;
            else        c_q <= c_q + 1'b1;
         end
         assign cnt = c_q;
      end
   endgenerate
endmodule

// File: rtl/itm_compare.sv
module itm_compare (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  itm_pkg::cmp_t load_val,
   input  itm_pkg::cmp_t cnt_lo,
   output itm_pkg::cmp_t cmp,
   output logic          hit
);
   itm_pkg::cmp_t cmp_q;

   always_ff @(posedge clk) begin
      if (!rst_n)    cmp_q <= '1;
      else if (load) cmp_q <= load_val;
   end

   assign cmp = cmp_q;
   assign hit = (cnt_lo == cmp_q);
endmodule

// File: rtl/itm_pending.sv
module itm_pending (
   input  logic clk,
   input  logic rst_n,
   input  logic hit,
   input  logic ack,
   output logic pend
);
   logic pend_q;

   always_ff @(posedge clk) begin
      if (!rst_n)   pend_q <= 1'b0;
      else if (hit) pend_q <= 1'b1;
      else if (ack) pend_q <= 1'b0;
   end

   assign pend = pend_q;
endmodule

// File: rtl/itm_timer.sv
module itm_timer #(
   parameter int                CNT_W      = 64,
   parameter int                ADDR_W     = 4,
   parameter logic [ADDR_W-1:0] TIMER_ADDR = '0,
   parameter logic [CNT_W-1:0]  INIT_COUNT = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic              reg_rd,
   input  logic              reg_wr,
   input  logic [31:0]       reg_wdata,
   output logic [CNT_W-1:0]  reg_rdata,
   input  logic              irq_mask_en,
   input  logic              irq_ack,
   output logic              irq
);
   localparam int LO_W = itm_pkg::CMP_W;

   generate
      if (CNT_W != LO_W && CNT_W != 2*LO_W) begin : g_bad_width
         $error("itm_timer: CNT_W must be 32 or 64");
      end
      if (ADDR_W < 1) begin : g_bad_addr
         $error("itm_timer: ADDR_W must be at least 1");
      end
   endgenerate

   logic [CNT_W-1:0] cnt_q;
   itm_pkg::cmp_t    cmp_q;
   logic             sel, wr_hit, match, pend_q;

   assign sel    = (reg_addr == TIMER_ADDR);
   assign wr_hit = reg_wr && sel;

   itm_counter #(.CNT_W(CNT_W), .INIT_COUNT(INIT_COUNT)) u_cnt (
      .clk (clk),
      .rst_n (rst_n),
      .cnt (cnt_q)
   );

   itm_compare u_cmp (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (wr_hit),
      .load_val (reg_wdata),
      .cnt_lo   (cnt_q[LO_W-1:0]),
      .cmp      (cmp_q),
      .hit      (match)
   );

   itm_pending u_pend (
      .clk   (clk),
      .rst_n (rst_n),
      .hit   (match),
      .ack   (irq_ack),
      .pend  (pend_q)
   );

   assign reg_rdata = (reg_rd && sel) ? cnt_q : '0;
   assign irq       = pend_q && irq_mask_en;
endmodule

// File: rtl/itm_timer_chk.sv
module itm_timer_chk #(
   parameter int                CNT_W      = 64,
   parameter int                ADDR_W     = 4,
   parameter logic [ADDR_W-1:0] TIMER_ADDR = '0
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] reg_addr,
   input logic              reg_rd,
   input logic              reg_wr,
   input logic [31:0]       reg_wdata,
   input logic [CNT_W-1:0]  reg_rdata,
   input logic              irq_mask_en,
   input logic              irq_ack,
   input logic              irq,
   input logic [CNT_W-1:0]  cnt_q,
   input logic [31:0]       cmp_q,
   input logic              pend_q
);
   // R1: one step per cycle once out of reset
   p_count_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> cnt_q == $past(cnt_q) + 1'b1);

   // R3: write at the timer address loads compare
   p_write_loads_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == TIMER_ADDR) |=> cmp_q == $past(reg_wdata));

   // R4: read returns the counter
   p_read_count_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rd && reg_addr == TIMER_ADDR) |-> reg_rdata == cnt_q);

   // R5: equality of the low half sets pending
   p_match_pends_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q[31:0] == cmp_q) |=> pend_q);

   // R6: pending only rises after a match
   p_rise_needs_match_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pend_q) |-> $past(cnt_q[31:0] == cmp_q));

   // R7: sticky without acknowledge
   p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q && !irq_ack) |=> pend_q);

   // R7: acknowledge clears when no match competes
   p_ack_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_ack && cnt_q[31:0] != cmp_q) |=> !pend_q);

   // R8: masked output stays low
   p_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_mask_en |-> !irq);
endmodule

bind itm_timer itm_timer_chk #(
   .CNT_W(CNT_W), .ADDR_W(ADDR_W), .TIMER_ADDR(TIMER_ADDR)
) u_chk (
   .clk (clk), .rst_n (rst_n), .reg_addr (reg_addr), .reg_rd (reg_rd),
   .reg_wr (reg_wr), .reg_wdata (reg_wdata), .reg_rdata (reg_rdata),
   .irq_mask_en (irq_mask_en), .irq_ack (irq_ack), .irq (irq),
   .cnt_q (cnt_q), .cmp_q (cmp_q), .pend_q (pend_q)
);

// File: tb/itm_timer_bench.sv
module itm_timer_bench;
   localparam int          CW   = 64;
   localparam logic [63:0] INIT = 64'h0000_0002_FFFF_F000;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [3:0]    reg_addr = 4'h0;
   logic          reg_rd = 1'b1;
   logic          reg_wr = 1'b0;
   logic [31:0]   reg_wdata = '0;
   logic [CW-1:0] reg_rdata;
   logic          irq_mask_en = 1'b1;
   logic          irq_ack = 1'b0;
   logic          irq;

   int n_chk = 0;
   int n_err = 0;

   always #5 clk = ~clk;

   itm_timer #(.CNT_W(CW), .ADDR_W(4), .TIMER_ADDR(4'h0), .INIT_COUNT(INIT)) u_itm_timer (
      .clk (clk), .rst_n (rst_n), .reg_addr (reg_addr), .reg_rd (reg_rd),
      .reg_wr (reg_wr), .reg_wdata (reg_wdata), .reg_rdata (reg_rdata),
      .irq_mask_en (irq_mask_en), .irq_ack (irq_ack), .irq (irq)
   );

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
      #1;
   endtask

   // write compare now, return counter seen in this cycle
   task automatic wr_cmp(input logic [3:0] a, input logic [31:0] v, output logic [63:0] c);
      c = reg_rdata;
      reg_addr = a; reg_wr = 1'b1; reg_wdata = v;
      tick();
      reg_wr = 1'b0; reg_addr = 4'h0;
      #1;
   endtask

   task automatic ack_pulse();
      irq_ack = 1'b1;
      tick();
      irq_ack = 1'b0;
      #1;
   endtask

   // write compare then check irq low one cycle before and high at the expected cycle
   task automatic arm_fire(input string req, input logic [31:0] v);
      logic [63:0] c;
      logic [31:0] d;
      tick();
      wr_cmp(4'h0, v, c);
      d = v - c[31:0];
      repeat (int'(d) - 1) tick();
      chk(req, {63'd0, irq}, 64'd0);
      tick();
      chk(req, {63'd0, irq}, 64'd1);
   endtask

   task automatic t_reset();
      tick();
      chk("R9 counter at reset", reg_rdata, INIT);
      chk("R9 irq at reset", {63'd0, irq}, 64'd0);
      chk("R2 upper bits visible", {32'd0, reg_rdata[63:32]}, 64'd2);
      rst_n = 1'b1;
      #1;
      chk("R1 first count", reg_rdata, INIT);
   endtask

   task automatic t_step();
      logic [63:0] a;
      tick(); a = reg_rdata;
      tick(); chk("R1 step", reg_rdata, a + 64'd1);
      tick(); chk("R1 step", reg_rdata, a + 64'd2);
   endtask

   task automatic t_read_decode();
      tick();
      reg_addr = 4'h3; #1;
      chk("R4 other address reads zero", reg_rdata, 64'd0);
      reg_addr = 4'h0; reg_rd = 1'b0; #1;
      chk("R4 no strobe reads zero", reg_rdata, 64'd0);
      reg_rd = 1'b1; #1;
   endtask

   task automatic t_write_only();
      logic [63:0] c;
      tick();
      wr_cmp(4'h0, 32'h1234_5678, c);
      chk("R3 R4 read after write is counter", reg_rdata, c + 64'd1);
   endtask

   task automatic t_fire_sticky();
      logic [63:0] c;
      irq_mask_en = 1'b1;
      tick(); c = reg_rdata;
      arm_fire("R5 match timing", c[31:0] + 32'd12);
      repeat (5) tick();
      chk("R7 pending sticky", {63'd0, irq}, 64'd1);
      ack_pulse();
      chk("R7 ack clears", {63'd0, irq}, 64'd0);
   endtask

   task automatic t_mask();
      logic [63:0] c;
      irq_mask_en = 1'b0;
      tick();
      wr_cmp(4'h0, reg_rdata[31:0] + 32'd8, c);
      repeat (10) tick();
      chk("R8 masked irq low", {63'd0, irq}, 64'd0);
      irq_mask_en = 1'b1; #1;
      chk("R8 masked event kept", {63'd0, irq}, 64'd1);
      ack_pulse();
   endtask

   task automatic t_collide();
      logic [63:0] c;
      logic [31:0] v;
      tick();
      v = reg_rdata[31:0] + 32'd6;
      wr_cmp(4'h0, v, c);
      repeat (5) tick();
      chk("R7 collide pre", {32'd0, reg_rdata[31:0]}, {32'd0, v});
      irq_ack = 1'b1;
      tick();
      irq_ack = 1'b0; #1;
      chk("R7 match beats ack", {63'd0, irq}, 64'd1);
      ack_pulse();
   endtask

   task automatic t_other_addr();
      logic [63:0] c;
      tick();
      wr_cmp(4'h5, reg_rdata[31:0] + 32'd4, c);
      chk("R4 other-address write keeps count", reg_rdata, c + 64'd1);
      repeat (20) tick();
      chk("R4 other-address write ignored", {63'd0, irq}, 64'd0);
   endtask

   task automatic t_wrap();
      arm_fire("R6 R5 fires after wrap", 32'h0000_0020);
      chk("R1 carry into upper half", {32'd0, reg_rdata[63:32]}, 64'd3);
      ack_pulse();
   endtask

   task automatic t_behind();
      logic [63:0] c;
      int bad;
      bad = 0;
      tick();
      wr_cmp(4'h0, reg_rdata[31:0] - 32'd5, c);
      for (int i = 0; i < 2000; i++) begin
         tick();
         if (irq !== 1'b0) bad++;
      end
      chk("R6 behind deadline silent", 64'(bad), 64'd0);
   endtask

   task automatic t_reset_cmp();
      rst_n = 1'b0;
      tick(); tick();
      chk("R9 pending cleared by reset", {63'd0, irq}, 64'd0);
      rst_n = 1'b1; #1;
      repeat (4095) tick();
      chk("R9 compare ones pre", {63'd0, irq}, 64'd0);
      tick();
      chk("R9 compare resets to ones", {63'd0, irq}, 64'd1);
      ack_pulse();
   endtask

   initial begin
      t_reset();
      t_step();
      t_read_decode();
      t_write_only();
      t_fire_sticky();
      t_mask();
      t_collide();
      t_other_addr();
      t_wrap();
      t_behind();
      t_reset_cmp();
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end
endmodule